// File: doc/BRIEF.md
# Line Activity Watchdog for AC Test Receivers

This block sits behind the signal recovery stage of a differential receiver during an AC test. It samples the recovered data bit on each enable of the test pattern clock and notes whether the bit changes between successive samples. At the end of every observation window it publishes a single error bit that reads 1 when the line showed no usable activity, together with a saturating count of rising transitions seen in that window.

A window ends on its own after a fixed number of pattern-clock enables, or earlier when the sync/capture strobe is pulsed. At that instant the verdict of the completed window is latched onto the outputs and the internal state starts afresh, so a capture always reads the outcome of a whole window of current line activity. A mode input selects between two verdicts. In window mode, a single change anywhere in the window is enough. In pair mode, every two adjacent samples must differ, which also exposes a line that is slow to change.

Top module: `act_watch`

## Requirements
- R1: While and after reset, with no window closed yet, `act_err`, `act_cnt` and `stuck_now` are all 0.
- R2: A sample is taken only in a cycle with `samp_en` high. Each sample is compared with the previous sample. The previous sample carries over across window boundaries. The first sample after reset has nothing to compare with.
- R3: A window closes on its own in the cycle of its WINDOW-th enable (WINDOW defaults to 16). The outputs show that window's result from the next cycle onward.
- R4: A `win_clr` pulse closes the current window in any cycle. A sample taken in that same cycle belongs to the window that is closing, and the next window starts with no samples.
- R5: With `pair_mode` = 0 when the window closes, `act_err` becomes 1 if the closed window held no change between compared samples, and 0 otherwise.
- R6: With `pair_mode` = 1 when the window closes, `act_err` becomes 1 if any compared pair of adjacent samples in the window was equal, and 0 otherwise.
- R7: `stuck_now` is 1 when `pair_mode` is 1 and an equal adjacent pair has been sampled in the open window. It rises in the cycle after that sample and stays high until the window closes.
- R8: `act_cnt` shows the number of 0-to-1 changes between compared samples in the closed window. The count saturates at 2^CNT_W-1, which is 31 by default.
- R9: `act_err` and `act_cnt` change only in the cycle after a window closes, and hold their values in every other cycle.
- R10: While `samp_en` is low, `data_in` is ignored. It produces no change, no count and no progress of the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| samp_en | input | 1 | Pattern-clock enable; marks a sample cycle |
| data_in | input | 1 | Recovered data bit from the receiver |
| win_clr | input | 1 | Sync/capture strobe; closes the current window |
| pair_mode | input | 1 | 0: any change passes; 1: every adjacent pair must differ |
| act_err | output | 1 | Latched no-activity verdict of the last closed window |
| act_cnt | output | CNT_W | Latched rising-change count of the last closed window |
| stuck_now | output | 1 | Live pair-mode indicator for the open window |

## Verification
Every result is one register away from its cause. `act_err` and `act_cnt` move in the cycle after the cycle in which a window closes, whether it closes through the WINDOW-th enable or through `win_clr`. `stuck_now` rises in the cycle after the first equal adjacent sample. The bench drives inputs and compares outputs on the falling edge, and updates a behavioural model on the rising edge. A comparison therefore always sees the effect of the edge just passed. Directed checks are placed one idle step after the closing stimulus. A second instance with a long window reaches count saturation, which a 16-sample window cannot reach.

// File: rtl/act_pkg.sv
package act_pkg;

    // Per-sample observation derived from the current and previous sample
    typedef struct packed {
        logic changed;   // compared sample differs from the previous one
        logic repeated;  // compared sample equals the previous one
        logic rising;    // change from 0 to 1
    } act_obs_t;

    typedef enum logic {
        VERDICT_ANY  = 1'b0,
        VERDICT_PAIR = 1'b1
    } act_verdict_e;

endpackage

// File: rtl/act_sampler.sv
module act_sampler
    import act_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     samp_en,
    input  logic     data_in,
    output act_obs_t obs
);

    typedef struct packed {
        logic last;
        logic have;
    } samp_st_t;

    samp_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        obs          = '0;
        if (samp_en) begin
            if (st_q.have) begin
                obs.changed  = (data_in != st_q.last);
                obs.repeated = (data_in == st_q.last);
                obs.rising   = data_in & ~st_q.last;
            end
            st_d.last = data_in;
            st_d.have = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2: the stored reference follows the sampled bit
    assert_ref_track_R2: assert property (@(posedge clk) disable iff (!rst_n)
        samp_en |=> (st_q.last == $past(data_in)) && st_q.have);

    // R10: without an enable the reference does not move
    assert_ref_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !samp_en |=> $stable(st_q));

endmodule

// File: rtl/act_window.sv
module act_window #(
    parameter int WINDOW = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic samp_en,
    input  logic win_clr,
    output logic close
);

    localparam int SLOT_W = (WINDOW > 1) ? $clog2(WINDOW) : 1;
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(WINDOW - 1);

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
    } win_st_t;

    win_st_t st_d, st_q;
    logic    wrap;

    always_comb begin
        st_d  = st_q;
        wrap  = samp_en && (st_q.slot == LAST_SLOT);
        close = win_clr | wrap;
        if (close) begin
            st_d.slot = '0;
        end else if (samp_en) begin
            st_d.slot = st_q.slot + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R4: a strobe restarts the window from its first slot
    assert_clr_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        win_clr |=> (st_q.slot == '0));

    // R3: a window never runs past its last slot
    assert_slot_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.slot == LAST_SLOT && samp_en) |=> (st_q.slot == '0));

    // R10: idle cycles do not advance the window
    assert_slot_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!samp_en && !win_clr) |=> $stable(st_q.slot));

endmodule

// File: rtl/act_tally.sv
module act_tally #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rising,
    input  logic             close,
    output logic [CNT_W-1:0] cnt_upd
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tally_st_t;

    tally_st_t st_d, st_q;

    always_comb begin
        cnt_upd = st_q.cnt;
        if (rising && (st_q.cnt != CNT_MAX)) begin
            cnt_upd = st_q.cnt + 1'b1;
        end
        st_d.cnt = close ? '0 : cnt_upd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R8: a full count stays full until the window closes
    assert_sat_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == CNT_MAX && !close) |=> (st_q.cnt == CNT_MAX));

    // R8: the running count restarts after a close
    assert_cnt_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        close |=> (st_q.cnt == '0));

endmodule

// File: rtl/act_watch.sv
module act_watch
    import act_pkg::*;
#(
    parameter int WINDOW = 16,
    parameter int CNT_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             samp_en,
    input  logic             data_in,
    input  logic             win_clr,
    input  logic             pair_mode,
    output logic             act_err,
    output logic [CNT_W-1:0] act_cnt,
    output logic             stuck_now
);

    typedef struct packed {
        logic             seen_change;
        logic             seen_repeat;
        logic             err;
        logic [CNT_W-1:0] cnt_out;
    } top_st_t;

    top_st_t          st_d, st_q;
    act_obs_t         obs;
    logic             close;
    logic [CNT_W-1:0] cnt_upd;
    logic             change_upd;
    logic             repeat_upd;
    act_verdict_e     verdict;

    act_sampler u_sampler (
        .clk     (clk),
        .rst_n   (rst_n),
        .samp_en (samp_en),
        .data_in (data_in),
        .obs     (obs)
    );

    act_window #(.WINDOW(WINDOW)) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .samp_en (samp_en),
        .win_clr (win_clr),
        .close   (close)
    );

    act_tally #(.CNT_W(CNT_W)) u_tally (
        .clk     (clk),
        .rst_n   (rst_n),
        .rising  (obs.rising),
        .close   (close),
        .cnt_upd (cnt_upd)
    );

    always_comb begin
        st_d       = st_q;
        verdict    = act_verdict_e'(pair_mode);
        change_upd = st_q.seen_change | obs.changed;
        repeat_upd = st_q.seen_repeat | obs.repeated;
        if (close) begin
            st_d.err         = (verdict == VERDICT_PAIR) ? repeat_upd : ~change_upd;
            st_d.cnt_out     = cnt_upd;
            st_d.seen_change = 1'b0;
            st_d.seen_repeat = 1'b0;
        end else begin
            st_d.seen_change = change_upd;
            st_d.seen_repeat = repeat_upd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_err   = st_q.err;
    assign act_cnt   = st_q.cnt_out;
    assign stuck_now = pair_mode & st_q.seen_repeat;

    // R9: published results move only after a window closes
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !close |=> ($stable(act_err) && $stable(act_cnt)));

    // R7: once an equal pair is seen it stays recorded until the close
    assert_repeat_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.seen_repeat && !close) |=> st_q.seen_repeat);

    // R6: a repeat in the closing cycle under pair mode gives an error
    assert_pair_verdict_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (close && pair_mode && (obs.repeated || st_q.seen_repeat)) |=> act_err);

    // R5: a change in the window under any-change mode clears the error
    assert_any_verdict_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (close && !pair_mode && (obs.changed || st_q.seen_change)) |=> !act_err);

endmodule

// File: tb/act_watch_bench.sv
module act_watch_bench;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 5;
    localparam int W_SHORT    = 16;
    localparam int W_LONG     = 128;
    localparam int CMAX       = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic samp_en = 1'b0;
    logic data_in = 1'b0;
    logic win_clr = 1'b0;
    logic pair_mode = 1'b0;

    logic             act_err, l_err;
    logic [CNT_W-1:0] act_cnt, l_cnt;
    logic             stuck_now, l_stuck;

    int checks = 0;
    int failures = 0;
    bit live = 1'b0;
    bit done = 1'b0;
    logic cur = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    act_watch #(.WINDOW(W_SHORT), .CNT_W(CNT_W)) u_act_watch (
        .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .data_in(data_in),
        .win_clr(win_clr), .pair_mode(pair_mode),
        .act_err(act_err), .act_cnt(act_cnt), .stuck_now(stuck_now)
    );

    act_watch #(.WINDOW(W_LONG), .CNT_W(CNT_W)) u_act_watch_long (
        .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .data_in(data_in),
        .win_clr(win_clr), .pair_mode(pair_mode),
        .act_err(l_err), .act_cnt(l_cnt), .stuck_now(l_stuck)
    );

    // Behavioural model, one slot per instance
    int m_prev[2], m_have[2], m_slot[2], m_chg[2], m_rep[2];
    int m_run[2], m_err[2], m_out[2];
    int m_win[2];

    initial begin
        m_win[0] = W_SHORT;
        m_win[1] = W_LONG;
        for (int k = 0; k < 2; k++) begin
            m_prev[k] = 0; m_have[k] = 0; m_slot[k] = 0; m_chg[k] = 0;
            m_rep[k] = 0; m_run[k] = 0; m_err[k] = 0; m_out[k] = 0;
        end
    end

    always @(posedge clk) begin
        for (int k = 0; k < 2; k++) begin
            if (!rst_n) begin
                m_prev[k] = 0; m_have[k] = 0; m_slot[k] = 0; m_chg[k] = 0;
                m_rep[k] = 0; m_run[k] = 0; m_err[k] = 0; m_out[k] = 0;
            end else begin
                int d;
                int ending;
                d = int'(data_in);
                if (samp_en && m_have[k] != 0) begin
                    if (d != m_prev[k]) begin
                        m_chg[k] = 1;
                        if (d == 1 && m_run[k] < CMAX) m_run[k]++;
                    end else begin
                        m_rep[k] = 1;
                    end
                end
                ending = (win_clr || (samp_en && m_slot[k] == m_win[k] - 1)) ? 1 : 0;
                if (ending != 0) begin
                    m_err[k] = pair_mode ? m_rep[k] : (m_chg[k] == 0 ? 1 : 0);
                    m_out[k] = m_run[k];
                    m_chg[k] = 0; m_rep[k] = 0; m_run[k] = 0; m_slot[k] = 0;
                end else if (samp_en) begin
                    m_slot[k]++;
                end
                if (samp_en) begin
                    m_prev[k] = d;
                    m_have[k] = 1;
                end
            end
        end
    end

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s got=%0d expected=%0d at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R5 R6 act_err", int'(act_err), m_err[0]);
        chk("R8 act_cnt", int'(act_cnt), m_out[0]);
        chk("R7 stuck_now", int'(stuck_now), (pair_mode && m_rep[0] != 0) ? 1 : 0);
        chk("R5 R6 long act_err", int'(l_err), m_err[1]);
        chk("R8 long act_cnt", int'(l_cnt), m_out[1]);
        chk("R7 long stuck_now", int'(l_stuck), (pair_mode && m_rep[1] != 0) ? 1 : 0);
    endtask

    task automatic step(input logic en, input logic d, input logic c, input logic m);
        @(negedge clk);
        if (live) compare_all();
        samp_en   = en;
        data_in   = d;
        win_clr   = c;
        pair_mode = m;
        if (en) cur = d;
    endtask

    task automatic idle(input logic m);
        step(1'b0, ~cur, 1'b0, m);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1 act_err reset", int'(act_err), 0);
        chk("R1 act_cnt reset", int'(act_cnt), 0);
        chk("R1 stuck_now reset", int'(stuck_now), 0);
        rst_n = 1'b1;
        live  = 1'b1;
        idle(1'b0);
        chk("R1 act_err after reset", int'(act_err), 0);

        // R3 R8 R2: alternating 1,0,... for 16 enables, auto close
        for (int i = 0; i < W_SHORT; i++) step(1'b1, (i % 2 == 0), 1'b0, 1'b0);
        idle(1'b0);
        chk("R3 auto close act_err", int'(act_err), 0);
        chk("R8 rising count", int'(act_cnt), 7);

        // R10: wiggling data without enable, then strobe closes an empty window
        for (int i = 0; i < 20; i++) step(1'b0, (i % 2 == 0), 1'b0, 1'b0);
        step(1'b0, 1'b1, 1'b1, 1'b0);
        idle(1'b0);
        chk("R10 ignored data act_err", int'(act_err), 1);
        chk("R10 ignored data act_cnt", int'(act_cnt), 0);

        // R5: held line for a full window
        for (int i = 0; i < W_SHORT; i++) step(1'b1, cur, 1'b0, 1'b0);
        idle(1'b0);
        chk("R5 held line act_err", int'(act_err), 1);
        chk("R5 held line act_cnt", int'(act_cnt), 0);

        // R9: activity inside an open window does not move results
        for (int i = 0; i < 5; i++) step(1'b1, ~cur, 1'b0, 1'b0);
        idle(1'b0);
        chk("R9 hold act_err", int'(act_err), 1);
        chk("R9 hold act_cnt", int'(act_cnt), 0);

        // R4: only change arrives with the strobe itself
        step(1'b0, cur, 1'b1, 1'b0);
        for (int i = 0; i < 3; i++) step(1'b1, cur, 1'b0, 1'b0);
        step(1'b1, ~cur, 1'b1, 1'b0);
        idle(1'b0);
        chk("R4 coincident sample act_err", int'(act_err), 0);

        // R6: pair mode, strictly alternating window
        step(1'b0, cur, 1'b1, 1'b1);
        for (int i = 0; i < 6; i++) step(1'b1, ~cur, 1'b0, 1'b1);
        step(1'b0, cur, 1'b1, 1'b1);
        idle(1'b1);
        chk("R6 alternating act_err", int'(act_err), 0);
        chk("R7 no repeat stuck_now", int'(stuck_now), 0);

        // R7 R6: one repeat inside the window
        for (int i = 0; i < 3; i++) step(1'b1, ~cur, 1'b0, 1'b1);
        step(1'b1, cur, 1'b0, 1'b1);
        idle(1'b1);
        chk("R7 stuck_now rises", int'(stuck_now), 1);
        step(1'b1, ~cur, 1'b0, 1'b1);
        idle(1'b1);
        chk("R7 stuck_now holds", int'(stuck_now), 1);
        step(1'b0, cur, 1'b1, 1'b1);
        idle(1'b1);
        chk("R6 repeat act_err", int'(act_err), 1);
        chk("R7 stuck_now cleared", int'(stuck_now), 0);

        // R8: saturation on the long window
        step(1'b0, cur, 1'b1, 1'b0);
        for (int i = 0; i < 80; i++) step(1'b1, ~cur, 1'b0, 1'b0);
        step(1'b0, cur, 1'b1, 1'b0);
        idle(1'b0);
        chk("R8 saturated count", int'(l_cnt), CMAX);
        chk("R8 saturated verdict", int'(l_err), 0);

        idle(1'b0);
        idle(1'b0);
        finish_run();
    end

endmodule